// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

A two-sided mailbox that sits between a host I/O bus and an embedded core, in the manner of a legacy keyboard/mouse controller. The host decodes two ports onto the block with two select inputs: a data port and a command/status port. Every host write, at either port, lands in a single input buffer that only the core reads. The block also records which port took the write, so firmware can tell a command from a data byte. The core fills an output buffer that the host drains by reading the data port.

A shared status byte carries three flags that the hardware manages: output buffer full, input buffer full, and the type of the last host write. The other five bits are free for firmware. The host reads this byte at the command/status port, and the core sees it all the time.

The block drives keyboard and mouse interrupts to the host. These come either from the output buffer state and a source bit, or straight from firmware-written bits. It also drives two level interrupts to the core, one for output buffer empty and one for input buffer full, each with its own enable. Firmware can run the channel by interrupt or by polling.

Top module: `kbc_mailbox`

## Requirements
- R1: `host_rdata` shows the status byte while `host_sel_cmd` is high, and the output buffer otherwise. A host read at the command select changes no flag. When both selects are high, the command select wins.
- R2: Status bit 0 is the output-buffer-full flag. A core output-buffer write sets it in the next cycle. A host read at the data select (with `host_sel_cmd` low) clears it. When a set and a clear fall in the same cycle, the set wins.
- R3: Status bit 1 is the input-buffer-full flag. A host write at either select loads the input buffer and sets the flag. A core read of the input buffer clears it. When a set and a clear fall in the same cycle, the set wins.
- R4: Status bit 3 and `core_ib_is_cmd` hold 1 if the most recent host write came through the command select, and 0 if it came through the data select.
- R5: Status bits 2, 4, 5, 6 and 7 take the matching bits of `core_stat_wdata` on a core status write. Host traffic and buffer traffic leave them unchanged.
- R6: A core control write loads the control fields from `core_ctl_wdata`:
  - bit 0: host interrupt mode (0 = hardware, 1 = firmware)
  - bit 1: firmware keyboard interrupt level
  - bit 2: firmware mouse interrupt level
  - bit 3: enable for the output-buffer-empty core interrupt
  - bit 4: enable for the input-buffer-full core interrupt
  - bit 5: output data source (0 = keyboard, 1 = mouse)
- R7: In hardware mode, `host_irq_kbd` equals the output-buffer-full flag when the source is keyboard. `host_irq_mouse` equals the flag when the source is mouse. In firmware mode, the two interrupts follow control bits 1 and 2.
- R8: `core_irq_obe` is high exactly when its enable is set and the output buffer is empty. `core_irq_ibf` is high exactly when its enable is set and the input buffer is full.
- R9: After reset, the buffers, the status byte, the control fields and all four interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_data | input | 1 | Host decode of the data port |
| host_sel_cmd | input | 1 | Host decode of the command/status port |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| host_irq_kbd | output | 1 | Keyboard interrupt to the host |
| host_irq_mouse | output | 1 | Mouse interrupt to the host |
| core_ob_wr | input | 1 | Core write of the output buffer |
| core_ob_wdata | input | DATA_W | Output buffer data from the core |
| core_ib_rd | input | 1 | Core read of the input buffer (clears full) |
| core_ib_rdata | output | DATA_W | Input buffer contents |
| core_ib_is_cmd | output | 1 | Last host write was a command |
| core_stat_wr | input | 1 | Core write of the firmware status bits |
| core_stat_wdata | input | 8 | Firmware status bits (2, 4 to 7 used) |
| core_ctl_wr | input | 1 | Core write of the control fields |
| core_ctl_wdata | input | 8 | Control fields (bits 0 to 5 used) |
| core_status | output | 8 | Shared status byte |
| core_irq_obe | output | 1 | Core interrupt: output buffer empty |
| core_irq_ibf | output | 1 | Core interrupt: input buffer full |

## Verification
The hardest situation to reach is a flag set and its clear in the same clock. That means a host write together with a core read of the input buffer, or a core output write together with a host data-port read. Random stimulus hits these cases only rarely.

Directed steps therefore drive both strobes in one cycle for each flag, and also assert both host selects at once. A long random phase then mixes every strobe, with the firmware mode and the source bit toggling underneath. A behavioural model is compared against all outputs every cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] FW_STAT_MASK = 8'hF4;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int CMD_BIT = 3;

    typedef struct packed {
        logic fw_mode;
        logic fw_kbd;
        logic fw_mouse;
        logic obe_en;
        logic ibf_en;
        logic src_mouse;
    } kbc_ctl_t;

    function automatic kbc_ctl_t ctl_unpack(input logic [7:0] v);
        kbc_ctl_t c;
        c.fw_mode   = v[0];
        c.fw_kbd    = v[1];
        c.fw_mouse  = v[2];
        c.obe_en    = v[3];
        c.ibf_en    = v[4];
        c.src_mouse = v[5];
        return c;
    endfunction
endpackage

// File: rtl/kbc_flag.sv
module kbc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set beats clear in the same cycle
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/kbc_irq.sv
module kbc_irq
    import kbc_pkg::*;
(
    input  kbc_ctl_t ctl_i,
    input  logic     obf_i,
    input  logic     ibf_i,
    output logic     host_kbd_o,
    output logic     host_mouse_o,
    output logic     core_obe_o,
    output logic     core_ibf_o
);
    always_comb begin
        if (ctl_i.fw_mode) begin
            host_kbd_o   = ctl_i.fw_kbd;
            host_mouse_o = ctl_i.fw_mouse;
        end else begin
            host_kbd_o   = obf_i & ~ctl_i.src_mouse;
            host_mouse_o = obf_i &  ctl_i.src_mouse;
        end
        core_obe_o = ctl_i.obe_en & ~obf_i;
        core_ibf_o = ctl_i.ibf_en &  ibf_i;
    end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
    import kbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_data,
    input  logic              host_sel_cmd,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq_kbd,
    output logic              host_irq_mouse,
    input  logic              core_ob_wr,
    input  logic [DATA_W-1:0] core_ob_wdata,
    input  logic              core_ib_rd,
    output logic [DATA_W-1:0] core_ib_rdata,
    output logic              core_ib_is_cmd,
    input  logic              core_stat_wr,
    input  logic [7:0]        core_stat_wdata,
    input  logic              core_ctl_wr,
    input  logic [7:0]        core_ctl_wdata,
    output logic [7:0]        core_status,
    output logic              core_irq_obe,
    output logic              core_irq_ibf
);
    typedef struct packed {
        logic [DATA_W-1:0] ib;
        logic              last_cmd;
        logic [DATA_W-1:0] ob;
        logic [STAT_W-1:0] fw_stat;
        kbc_ctl_t          ctl;
    } regs_t;

    regs_t r_d, r_q;
    logic  host_wr_hit, host_rd_data;
    logic  obf, ibf;
    logic [STAT_W-1:0] status;

    assign host_wr_hit  = host_wr & (host_sel_data | host_sel_cmd);
    assign host_rd_data = host_rd & host_sel_data & ~host_sel_cmd;

    always_comb begin
        r_d = r_q;
        if (host_wr_hit) begin
            r_d.ib       = host_wdata;
            r_d.last_cmd = host_sel_cmd;
        end
        if (core_ob_wr)   r_d.ob      = core_ob_wdata;
        if (core_stat_wr) r_d.fw_stat = core_stat_wdata & FW_STAT_MASK;
        if (core_ctl_wr)  r_d.ctl     = ctl_unpack(core_ctl_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    kbc_flag u_obf (.clk(clk), .rst_n(rst_n), .set_i(core_ob_wr),  .clr_i(host_rd_data), .flag_o(obf));
    kbc_flag u_ibf (.clk(clk), .rst_n(rst_n), .set_i(host_wr_hit), .clr_i(core_ib_rd),   .flag_o(ibf));

    always_comb begin
        status          = r_q.fw_stat;
        status[OBF_BIT] = obf;
        status[IBF_BIT] = ibf;
        status[CMD_BIT] = r_q.last_cmd;
    end

    logic [DATA_W-1:0] status_wide;
    generate
        if (DATA_W == STAT_W) begin : g_same
            assign status_wide = status;
        end else begin : g_pad
            assign status_wide = {{(DATA_W-STAT_W){1'b0}}, status};
        end
    endgenerate

    assign host_rdata     = host_sel_cmd ? status_wide : r_q.ob;
    assign core_ib_rdata  = r_q.ib;
    assign core_ib_is_cmd = r_q.last_cmd;
    assign core_status    = status;

    kbc_irq u_irq (
        .ctl_i        (r_q.ctl),
        .obf_i        (obf),
        .ibf_i        (ibf),
        .host_kbd_o   (host_irq_kbd),
        .host_mouse_o (host_irq_mouse),
        .core_obe_o   (core_irq_obe),
        .core_ibf_o   (core_irq_ibf)
    );
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel_data,
    input logic       host_sel_cmd,
    input logic       host_wr,
    input logic       host_rd,
    input logic       core_ob_wr,
    input logic       core_ib_rd,
    input logic       core_stat_wr,
    input logic [7:0] core_status,
    input logic       core_ib_is_cmd,
    input logic       core_irq_obe,
    input logic       core_irq_ibf
);
    logic hw_hit, hr_data;
    assign hw_hit  = host_wr & (host_sel_data | host_sel_cmd);
    assign hr_data = host_rd & host_sel_data & ~host_sel_cmd;

    a_r2_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        core_ob_wr |=> core_status[0]);
    a_r2_obf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_data && !core_ob_wr) |=> !core_status[0]);
    a_r3_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> core_status[1]);
    a_r3_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ib_rd && !hw_hit) |=> !core_status[1]);
    a_r4_cmd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        hw_hit |=> (core_status[3] == $past(host_sel_cmd)) && (core_ib_is_cmd == core_status[3]));
    a_r5_fw_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !core_stat_wr |=> $stable({core_status[7:4], core_status[2]}));
    a_r8_obe_level: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_obe |-> !core_status[0]);
    a_r8_ibf_level: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq_ibf |-> core_status[1]);
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_sel_data(host_sel_data), .host_sel_cmd(host_sel_cmd),
    .host_wr(host_wr), .host_rd(host_rd),
    .core_ob_wr(core_ob_wr), .core_ib_rd(core_ib_rd), .core_stat_wr(core_stat_wr),
    .core_status(core_status), .core_ib_is_cmd(core_ib_is_cmd),
    .core_irq_obe(core_irq_obe), .core_irq_ibf(core_irq_ibf)
);

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
    logic clk = 0, rst_n = 0;
    logic sel_d = 0, sel_c = 0, hwr = 0, hrd = 0;
    logic [7:0] hwdata = 0, hrdata;
    logic irq_k, irq_m;
    logic obwr = 0, ibrd = 0, stwr = 0, ctwr = 0;
    logic [7:0] obdata = 0, ibdata, stdata = 0, ctdata = 0, status;
    logic is_cmd, irq_obe, irq_ibf;

    always #10 clk = ~clk;   // 50 MHz

    kbc_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel_data(sel_d), .host_sel_cmd(sel_c), .host_wr(hwr), .host_rd(hrd),
        .host_wdata(hwdata), .host_rdata(hrdata),
        .host_irq_kbd(irq_k), .host_irq_mouse(irq_m),
        .core_ob_wr(obwr), .core_ob_wdata(obdata),
        .core_ib_rd(ibrd), .core_ib_rdata(ibdata), .core_ib_is_cmd(is_cmd),
        .core_stat_wr(stwr), .core_stat_wdata(stdata),
        .core_ctl_wr(ctwr), .core_ctl_wdata(ctdata),
        .core_status(status), .core_irq_obe(irq_obe), .core_irq_ibf(irq_ibf)
    );

    int checks = 0, errors = 0;
    // reference model
    int m_ib = 0, m_ob = 0, m_fw = 0, m_ctl = 0;
    bit m_ibf = 0, m_obf = 0, m_cmd = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_status();
        return (m_fw & 'hF4) | (m_cmd ? 8 : 0) | (m_ibf ? 2 : 0) | (m_obf ? 1 : 0);
    endfunction

    task automatic compare();
        int st = m_status();
        bit fwm = m_ctl[0], src = m_ctl[5];
        chk("R1 host_rdata", hrdata, sel_c ? st : m_ob);
        chk("R2/R3/R4/R5 status", status, st);
        chk("R3 ib data", ibdata, m_ib);
        chk("R4 is_cmd", is_cmd, m_cmd);
        chk("R7 irq_kbd", irq_k, fwm ? m_ctl[1] : (m_obf && !src));
        chk("R7 irq_mouse", irq_m, fwm ? m_ctl[2] : (m_obf && src));
        chk("R8 irq_obe", irq_obe, m_ctl[3] && !m_obf);
        chk("R8 irq_ibf", irq_ibf, m_ctl[4] && m_ibf);
    endtask

    task automatic idle();
        sel_d = 0; sel_c = 0; hwr = 0; hrd = 0; obwr = 0; ibrd = 0; stwr = 0; ctwr = 0;
    endtask

    // inputs already set; advance one edge, update model, compare, clear strobes
    task automatic tick();
        bit hw, hr;
        @(posedge clk);
        hw = hwr && (sel_d || sel_c);
        hr = hrd && sel_d && !sel_c;
        if (hw) begin m_ib = hwdata; m_cmd = sel_c; end
        if (obwr) m_ob = obdata;
        if (stwr) m_fw = stdata & 'hF4;
        if (ctwr) m_ctl = ctdata & 'h3F;
        if (hw) m_ibf = 1; else if (ibrd) m_ibf = 0;
        if (obwr) m_obf = 1; else if (hr) m_obf = 0;
        #2;
        compare();
        idle();
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare();                 // R9 reset state
        chk("R9 rdata after reset", hrdata, 0);
        rst_n = 1;
        tick();

        // R3/R4 host data write, then command write
        sel_d = 1; hwr = 1; hwdata = 8'h5A; tick();
        chk("R4 data write bit3", status[3], 0);
        sel_c = 1; hwr = 1; hwdata = 8'hD1; tick();
        chk("R4 command write bit3", status[3], 1);
        // R3 set beats clear
        sel_d = 1; hwr = 1; hwdata = 8'h11; ibrd = 1; tick();
        chk("R3 set wins", status[1], 1);
        ibrd = 1; tick();
        chk("R3 cleared", status[1], 0);
        // R1 both selects: command wins
        sel_d = 1; sel_c = 1; hwr = 1; hwdata = 8'h22; tick();
        chk("R1 both selects as command", is_cmd, 1);
        // R6/R7 hardware mode, keyboard source, then output write
        ctwr = 1; ctdata = 8'h18; tick();
        obwr = 1; obdata = 8'hA5; tick();
        chk("R7 kbd irq from obf", irq_k, 1);
        // R1 status read does not clear obf
        sel_c = 1; hrd = 1; tick();
        chk("R1 status read keeps obf", status[0], 1);
        // R2 set beats clear
        sel_d = 1; hrd = 1; obwr = 1; obdata = 8'h3C; tick();
        chk("R2 set wins", status[0], 1);
        sel_d = 1; hrd = 1; tick();
        chk("R2 cleared by data read", status[0], 0);
        // R7 mouse source
        ctwr = 1; ctdata = 8'h20; tick();
        obwr = 1; obdata = 8'h77; tick();
        chk("R7 mouse irq", irq_m, 1);
        // R5 firmware status bits, host traffic leaves them
        stwr = 1; stdata = 8'hFF; tick();
        chk("R5 fw bits", status & 8'hF4, 8'hF4);
        sel_d = 1; hwr = 1; hwdata = 8'h00; tick();
        chk("R5 fw bits kept", status & 8'hF4, 8'hF4);
        // R7 firmware mode
        ctwr = 1; ctdata = 8'h05; tick();
        chk("R7 fw kbd", irq_k, 0);
        chk("R7 fw mouse", irq_m, 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 16;
            sel_d = r[0]; sel_c = ($urandom % 3) == 0;
            hwr = ($urandom % 4) == 0; hrd = ($urandom % 3) == 0;
            hwdata = 8'($urandom);
            obwr = ($urandom % 4) == 0; obdata = 8'($urandom);
            ibrd = ($urandom % 3) == 0;
            stwr = ($urandom % 10) == 0; stdata = 8'($urandom);
            ctwr = ($urandom % 12) == 0; ctdata = 8'($urandom);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule